// File: doc/BRIEF.md
# Port Reset Sequencer

This block owns the reset lines of one serial-link port. A single software-written control register holds one release bit per reset domain: PHY, PIPE, MAC, configuration space and the endpoint reset (PERST). Every reset output is active low, so a cleared bit keeps its domain in reset. Bring-up software first releases the four internal resets together. It releases PERST only after a long settling delay.

A second job is recovery from link loss. When the auto-reset field is armed and the link status falls from up to down, the block drives a timed reset pulse into the MAC and configuration domains. The stored register bits are not changed by this pulse. A status register reports the registered link-up state. It also holds a sticky flag that records an attempt to release PERST before a minimum delay has run out. While that delay is pending, the block holds PERST in reset by itself.

Top module: `port_rst_seq`

## Requirements
- R1: Control bit 0 releases the PHY reset, bit 1 the PIPE reset, bit 2 the MAC reset, bit 3 the configuration reset and bit 8 PERST. A reset output is high only when its bit is 1. `phy_rst_no` and `pipe_rst_no` always equal bits 0 and 1. `perst_no` is never high while bit 8 is 0.
- R2: After reset, and after any write of 0x0000, the control register reads 0 and all five reset outputs are low from the next cycle on.
- R3: Only bits 0-3, 8 and 13-15 are stored. A write is visible on `ctrl_o` in the following cycle, and all other bits read as 0.
- R4: Auto-reset is armed when any of control bits 15:13 is 1. A link fall seen between two clock edges drives `mac_rst_no` and `cfg_rst_no` low from the next edge for exactly PULSE_CYCLES cycles. PHY, PIPE and PERST are not affected.
- R5: The auto-reset pulse never changes `ctrl_o`. The control register changes only on a write.
- R6: Only a 1-to-0 step of the registered link state triggers a pulse. A link that stays low, a link that rises, or a fall while bits 15:13 are all 0 gives no pulse.
- R7: Status bit 11 shows `link_up_i` delayed by one clock. Status bits other than 11 and 0 read 0.
- R8: With PERST_GATE=1, `perst_no` goes high only once control bits 3:0 have all been 1 for PERST_MIN_DLY clock edges in a row. Clearing any of them restarts the count. A stored early bit 8 releases PERST by itself once the count completes.
- R9: Status bit 0 is set by a write with bit 8 = 1 while the delay of R8 is not yet complete. It stays set until a write of 0x0000.
- R10: A second link fall during a running pulse restarts the pulse at its full length.
- R11: With PERST_GATE=0, `perst_no` follows control bit 8 with no delay, and status bit 0 never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control register write data |
| link_up_i | input | 1 | Link-up indication from the link layer |
| ctrl_o | output | 16 | Control register readback |
| status_o | output | 16 | Status: bit 11 link up, bit 0 early PERST attempt |
| phy_rst_no | output | 1 | PHY reset, active low |
| pipe_rst_no | output | 1 | PIPE reset, active low |
| mac_rst_no | output | 1 | MAC reset, active low |
| cfg_rst_no | output | 1 | Configuration-space reset, active low |
| perst_no | output | 1 | Endpoint reset, active low |

## Verification
Each of the 16 control bits is written on its own. This shows which bits are stored and which reset line each one drives. A sweep then varies the wait between releasing the internal resets and setting bit 8, from zero up to past the minimum delay. Each wait gives a predicted violation flag and PERST level, which separates the last early wait from the first legal one. The link input is driven through a fall, a held low level, a rise, a fall with auto-reset disarmed, and a double fall inside one pulse. Together these separate true edge detection from level detection and show whether the pulse reloads. An ungated instance shares the same stimulus, so its immediate PERST release can be compared with the gated one.

// File: rtl/port_rst_pkg.sv
package port_rst_pkg;
  localparam int REG_W    = 16;
  localparam int B_PHY    = 0;
  localparam int B_PIPE   = 1;
  localparam int B_MAC    = 2;
  localparam int B_CFG    = 3;
  localparam int B_PERST  = 8;
  localparam int B_AR_LO  = 13;
  localparam int B_AR_HI  = 15;
  localparam int ST_LINK  = 11;
  localparam int ST_EARLY = 0;
  localparam logic [REG_W-1:0] STORE_MASK = 16'hE10F;
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/prs_ctrl_reg.sv
module prs_ctrl_reg
  import port_rst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  reg_t wr_data_i,
  input  logic dly_done_i,
  output reg_t ctrl_o,
  output logic early_o
);
  reg_t ctrl_q;
  logic early_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      early_q <= 1'b0;
    end else if (wr_en_i) begin
      ctrl_q <= wr_data_i & STORE_MASK;
      if (wr_data_i == '0)                          early_q <= 1'b0;
      else if (wr_data_i[B_PERST] && !dly_done_i)  early_q <= 1'b1;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign early_o = early_q;
endmodule

// File: rtl/prs_link_mon.sv
module prs_link_mon #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_up_i,
  input  logic ar_en_i,
  output logic link_q_o,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic          link_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  // true 1->0 step against registered state
  assign fall = ar_en_i & link_q & ~link_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      link_q <= link_up_i;
      if (fall)             cnt_q <= LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign link_q_o = link_q;
  assign pulse_o  = (cnt_q != '0);
endmodule

// File: rtl/prs_perst_gate.sv
module prs_perst_gate #(
  parameter int PERST_MIN_DLY = 100000,
  parameter bit PERST_GATE    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_rel_i,
  output logic done_o
);
  localparam int DW = $clog2(PERST_MIN_DLY + 1);
  localparam logic [DW-1:0] LIM = DW'(PERST_MIN_DLY);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!int_rel_i)    cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERST_GATE) begin : g_gate
      assign done_o = (cnt_q == LIM);
    end else begin : g_nogate
      assign done_o = 1'b1 | (cnt_q == LIM);
    end
  endgenerate
endmodule

// File: rtl/port_rst_seq.sv
module port_rst_seq
  import port_rst_pkg::*;
#(
  parameter int PULSE_CYCLES  = 16,
  parameter int PERST_MIN_DLY = 100000,
  parameter bit PERST_GATE    = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        link_up_i,
  output logic [15:0] ctrl_o,
  output logic [15:0] status_o,
  output logic        phy_rst_no,
  output logic        pipe_rst_no,
  output logic        mac_rst_no,
  output logic        cfg_rst_no,
  output logic        perst_no
);
  reg_t ctrl;
  logic early, dly_done, link_q, pulse, ar_en, int_rel;

  assign ar_en   = |ctrl[B_AR_HI:B_AR_LO];
  assign int_rel = &ctrl[B_CFG:B_PHY];

  prs_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .dly_done_i(dly_done), .ctrl_o(ctrl), .early_o(early)
  );

  prs_link_mon #(.PULSE_CYCLES(PULSE_CYCLES)) u_mon (
    .clk_i, .rst_ni, .link_up_i, .ar_en_i(ar_en),
    .link_q_o(link_q), .pulse_o(pulse)
  );

  prs_perst_gate #(.PERST_MIN_DLY(PERST_MIN_DLY), .PERST_GATE(PERST_GATE)) u_gate (
    .clk_i, .rst_ni, .int_rel_i(int_rel), .done_o(dly_done)
  );

  always_comb begin
    status_o           = '0;
    status_o[ST_LINK]  = link_q;
    status_o[ST_EARLY] = early;
  end

  assign ctrl_o      = ctrl;
  assign phy_rst_no  = ctrl[B_PHY];
  assign pipe_rst_no = ctrl[B_PIPE];
  assign mac_rst_no  = ctrl[B_MAC] & ~pulse;
  assign cfg_rst_no  = ctrl[B_CFG] & ~pulse;
  assign perst_no    = ctrl[B_PERST] & dly_done;
endmodule

// File: rtl/port_rst_seq_chk.sv
module port_rst_seq_chk #(
  parameter int PERST_MIN_DLY = 100000,
  parameter bit PERST_GATE    = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic        link_up_i,
  input logic [15:0] ctrl_o,
  input logic        link_st_i,
  input logic        phy_rst_no,
  input logic        pipe_rst_no,
  input logic        mac_rst_no,
  input logic        cfg_rst_no,
  input logic        perst_no
);
  localparam int DW = $clog2(PERST_MIN_DLY + 1);
  localparam logic [DW-1:0] LIM = DW'(PERST_MIN_DLY);
  logic [DW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!(&ctrl_o[3:0])) run_q <= '0;
    else if (run_q != LIM)    run_q <= run_q + 1'b1;
  end

  AST_ZERO_WRITE_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == 16'h0) |=> (!phy_rst_no && !pipe_rst_no && !mac_rst_no && !cfg_rst_no && !perst_no)); // R2
  AST_PHY_PIPE_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_rst_no == ctrl_o[0]) && (pipe_rst_no == ctrl_o[1])); // R1
  AST_PERST_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perst_no |-> ctrl_o[8]); // R1
  AST_FALL_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ctrl_o[15:13]) && link_st_i && !link_up_i) |=> (!mac_rst_no && !cfg_rst_no)); // R4
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_o)); // R5
  AST_LINK_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (link_st_i == $past(link_up_i))); // R7
  AST_PERST_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perst_no && PERST_GATE) |-> (run_q == LIM)); // R8
endmodule

bind port_rst_seq port_rst_seq_chk #(.PERST_MIN_DLY(PERST_MIN_DLY), .PERST_GATE(PERST_GATE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .link_up_i(link_up_i), .ctrl_o(ctrl_o), .link_st_i(status_o[11]),
  .phy_rst_no(phy_rst_no), .pipe_rst_no(pipe_rst_no), .mac_rst_no(mac_rst_no),
  .cfg_rst_no(cfg_rst_no), .perst_no(perst_no)
);

// File: tb/port_rst_seq_test.sv
module port_rst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 4;
  localparam int MIN = 6;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, link = 1'b0;
  logic [15:0] wdat = '0;
  logic [15:0] ctrl, stat, ctrl2, stat2;
  logic phy, pipe, mac, cfg, perst, phy2, pipe2, mac2, cfg2, perst2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_rst_seq #(.PULSE_CYCLES(P), .PERST_MIN_DLY(MIN), .PERST_GATE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wdat), .link_up_i(link),
    .ctrl_o(ctrl), .status_o(stat), .phy_rst_no(phy), .pipe_rst_no(pipe),
    .mac_rst_no(mac), .cfg_rst_no(cfg), .perst_no(perst));

  port_rst_seq #(.PULSE_CYCLES(P), .PERST_MIN_DLY(MIN), .PERST_GATE(1'b0)) uut_ng (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wdat), .link_up_i(link),
    .ctrl_o(ctrl2), .status_o(stat2), .phy_rst_no(phy2), .pipe_rst_no(pipe2),
    .mac_rst_no(mac2), .cfg_rst_no(cfg2), .perst_no(perst2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge, after capture
  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wdat = d;
    @(negedge clk);
    wr_en = 1'b0; wdat = '0;
  endtask

  task automatic outs(input string tag, input logic [4:0] exp);
    chk(tag, {phy, pipe, mac, cfg, perst}, {27'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset ctrl", ctrl, 0);
    chk("R2 reset status", stat, 0);
    outs("R2 reset outs", 5'b00000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R3: single-bit sweep
    for (int b = 0; b < 16; b++) begin
      logic [15:0] v;
      v = 16'(1) << b;
      wr(v);
      chk("R3 readback", ctrl, v & 16'hE10F);
      outs("R1 bit map", {b == 0, b == 1, b == 2, b == 3, 1'b0});
      wr(16'h0000);
    end

    // R8/R9: delay sweep
    for (int d = 0; d <= MIN + 2; d++) begin
      wr(16'h000F);
      repeat (d) @(negedge clk);
      wr(16'h010F);
      chk("R9 early flag", stat[0], (d < MIN));
      chk("R8 perst level", perst, (d + 1 >= MIN));
      chk("R11 ungated perst", perst2, 1);
      chk("R11 ungated flag", stat2[0], 0);
      repeat (MIN) @(negedge clk);
      chk("R8 auto release", perst, 1);
      chk("R9 sticky", stat[0], (d < MIN));
      wr(16'h0000);
      chk("R9 clear", stat[0], 0);
      outs("R2 zero write", 5'b00000);
    end

    // R8: clearing an internal bit restarts the count
    wr(16'h000F);
    repeat (MIN - 2) @(negedge clk);
    wr(16'h0007);
    wr(16'h010F);
    repeat (MIN - 2) @(negedge clk);
    chk("R8 restart held", perst, 0);
    repeat (3) @(negedge clk);
    chk("R8 restart release", perst, 1);

    // R7
    link = 1'b1;
    chk("R7 delay", stat[11], 0);
    @(negedge clk);
    chk("R7 link up", stat[11], 1);
    chk("R7 other bits", stat & 16'hF7FE, 0);

    // R4/R5: single pulse
    wr(16'hE10F);
    @(negedge clk);
    outs("R1 all released", 5'b11111);
    link = 1'b0;
    for (int i = 0; i <= P + 2; i++) begin
      logic lo;
      lo = (i >= 1) && (i <= P);
      outs("R4 pulse", {1'b1, 1'b1, !lo, !lo, 1'b1});
      chk("R5 ctrl kept", ctrl, 16'hE10F);
      @(negedge clk);
    end

    // R6: staying low and rising give no pulse
    repeat (3) begin
      outs("R6 low hold", 5'b11111);
      @(negedge clk);
    end
    link = 1'b1;
    repeat (3) begin
      outs("R6 rise", 5'b11111);
      @(negedge clk);
    end
    // R6: disarmed fall
    wr(16'h010F);
    link = 1'b0;
    repeat (P + 1) begin
      outs("R6 disarmed", 5'b11111);
      @(negedge clk);
    end

    // R10: re-trigger
    wr(16'hE10F);
    link = 1'b1;
    repeat (2) @(negedge clk);
    link = 1'b0;
    for (int i = 0; i <= P + 5; i++) begin
      logic lo;
      if (i == 2) link = 1'b1;
      if (i == 3) link = 1'b0;
      lo = (i >= 1) && (i <= P + 3);
      chk("R10 retrigger mac", mac, !lo);
      chk("R10 retrigger cfg", cfg, !lo);
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule